// File: doc/BRIEF.md
# Match/Capture Register Bank

This block holds a small bank of 32-bit timer registers. Each register either compares its stored value with the running timer counter and raises a strobe on equality, or latches the counter when one of a chosen set of events fires. Every register also carries a reload shadow. In compare mode the shadow is copied into the live value when the counter signals its limit (or reaching zero while counting down). Software sets up and inspects the bank through a simple write port and an indexed read port.

The bank runs in one of two layouts, chosen by the `split` input. In the unified layout each register is a single 32-bit quantity compared against, and captured from, the full 32-bit counter. Its low-half controls govern the whole word. In the split layout each register breaks into two independent 16-bit halves. The low half follows the low counter (`cnt[15:0]`, limit pulse `lim_lo`) and the high half follows the high counter (`cnt[31:16]`, limit pulse `lim_hi`). Each half has its own role bit, its own event mask and its own strobe.

Top module: `mcr_bank`

## Requirements
- R1: Synchronous active-high reset clears every stored value, reload shadow, role bit and event mask to 0. In the first cycle after reset is released, `match_lo` and `match_hi` are all 0.
- R2: A write with `wr_en`=1 to register `wr_idx` acts at the clock edge. `wr_sel` codes: 0 = live value, 1 = reload shadow, 2 = role bits (`wr_data[0]` low half, `wr_data[1]` high half; 1 = capture, 0 = compare), 3 = low event mask, 4 = high event mask (both taken from `wr_data[NEV-1:0]`). Codes 5 to 7 change nothing. For codes 0 and 1, `wr_be[0]` enables bits 15:0 and `wr_be[1]` enables bits 31:16. `rd_data` shows the live value of register `rd_idx` combinationally.
- R3: Unified layout: `match_lo[i]` is 1 in the cycle after the edge at which the full 32-bit `cnt` equals register i's value and i's low role bit is 0. `match_hi` stays 0.
- R4: Split layout: `match_lo[i]` (resp. `match_hi[i]`) is 1 in the cycle after an edge at which `cnt[15:0]` equals value bits 15:0 (resp. `cnt[31:16]` equals bits 31:16) and that half's role bit is 0.
- R5: Unified layout: when the low role bit is 1 and any event bit set in `ev` is also set in the low mask, the whole 32-bit `cnt` is latched into the value at that edge.
- R6: Split layout: each half captures its counter half on its own role bit and its own mask, leaving the other half untouched.
- R7: In compare role, `lim_lo` loads the reload shadow into the value: the whole word in the unified layout, bits 15:0 in the split layout. In the split layout `lim_hi` loads bits 31:16 only.
- R8: In one cycle and per half, a bus write to the live value overrides a capture, and a capture overrides a reload. A half not written in that cycle still captures or reloads.
- R9: A register half in capture role never raises a strobe. A half in compare role ignores `ev`. Event bits outside a capture mask have no effect.
- R10: In the unified layout the high role bit, the high mask and `lim_hi` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split | input | 1 | 1 = two 16-bit halves, 0 = unified 32-bit |
| cnt | input | 32 | Counter value (split: high counter in 31:16, low in 15:0) |
| ev | input | NEV | Event pulses, one bit per event |
| lim_lo | input | 1 | Limit/zero pulse of the low (or unified) counter |
| lim_hi | input | 1 | Limit/zero pulse of the high counter |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target code (see R2) |
| wr_idx | input | IW | Register index for writes |
| wr_data | input | 32 | Write data |
| wr_be | input | 2 | Half enables for value and reload writes |
| rd_idx | input | IW | Register index for reads |
| rd_data | output | 32 | Live value of register `rd_idx` |
| match_lo | output | NREG | Low-half (or unified) match strobes |
| match_hi | output | NREG | High-half match strobes |

## Verification
Strobes are registered, so a counter value presented before an edge shows up on `match_lo`/`match_hi` one cycle later. Captures, reloads and bus writes change the stored value at the same edge, so they show up on `rd_data` right after that edge. The bench changes inputs 2 ns after each rising edge and samples on the falling edge. A behavioural model updated at each rising edge is compared with the outputs at every falling edge. Directed checks with hand-worked values cover write priority, half independence and the unified-mode rules.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int HW = 16;

    typedef enum logic [2:0] {
        WS_VALUE   = 3'd0,
        WS_RELOAD  = 3'd1,
        WS_MODE    = 3'd2,
        WS_MASK_LO = 3'd3,
        WS_MASK_HI = 3'd4
    } wsel_e;

    // write request seen by one 16-bit half
    typedef struct packed {
        logic          wv;   // write live value
        logic          wr;   // write reload shadow
        logic [HW-1:0] d;
    } half_wr_t;
endpackage

// File: rtl/mcr_half.sv
module mcr_half
    import mcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  half_wr_t      wr,
    input  logic          cap,
    input  logic          rld,
    input  logic [HW-1:0] cnt,
    output logic [HW-1:0] value,
    output logic          eq
);
    logic [HW-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value    <= '0;
            shadow_q <= '0;
        end else begin
            if (wr.wr)
                shadow_q <= wr.d;
            // bus write > capture > reload
            if (wr.wv)
                value <= wr.d;
            else if (cap)
                value <= cnt;
            else if (rld)
                value <= shadow_q;
        end
    end

    assign eq = (value == cnt);
endmodule

// File: rtl/mcr_slot.sv
module mcr_slot
    import mcr_pkg::*;
#(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           split,
    input  logic [31:0]    cnt,
    input  logic [NEV-1:0] ev,
    input  logic           lim_lo,
    input  logic           lim_hi,
    input  logic           sel_me,
    input  wsel_e          wsel,
    input  logic [31:0]    wdata,
    input  logic [1:0]     wbe,
    output logic [31:0]    value,
    output logic           match_lo,
    output logic           match_hi,
    output logic           mode_lo,
    output logic           mode_hi
);
    logic [1:0]          mode_q;
    logic [1:0][NEV-1:0] mask_q;
    logic [1:0]          hit, cap, rld, eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '0;
        end else if (sel_me) begin
            case (wsel)
                WS_MODE:    mode_q    <= wdata[1:0];
                WS_MASK_LO: mask_q[0] <= wdata[NEV-1:0];
                WS_MASK_HI: mask_q[1] <= wdata[NEV-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        for (int h = 0; h < 2; h++)
            hit[h] = mode_q[h] && ((ev & mask_q[h]) != '0);
        cap[0] = hit[0];
        rld[0] = !mode_q[0] && lim_lo;
        cap[1] = split ? hit[1] : hit[0];
        rld[1] = split ? (!mode_q[1] && lim_hi) : rld[0];
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        half_wr_t hwr;
        assign hwr = '{wv: sel_me && (wsel == WS_VALUE)  && wbe[h],
                       wr: sel_me && (wsel == WS_RELOAD) && wbe[h],
                       d:  wdata[h*HW +: HW]};
        mcr_half u_half (
            .clk   (clk),
            .rst   (rst),
            .wr    (hwr),
            .cap   (cap[h]),
            .rld   (rld[h]),
            .cnt   (cnt[h*HW +: HW]),
            .value (value[h*HW +: HW]),
            .eq    (eq[h])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_lo <= 1'b0;
            match_hi <= 1'b0;
        end else begin
            match_lo <= !mode_q[0] && eq[0] && (split || eq[1]);
            match_hi <= split && !mode_q[1] && eq[1];
        end
    end

    assign mode_lo = mode_q[0];
    assign mode_hi = mode_q[1];
endmodule

// File: rtl/mcr_bank.sv
module mcr_bank
    import mcr_pkg::*;
#(
    parameter int NREG = 4,
    parameter int NEV  = 8,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            split,
    input  logic [31:0]     cnt,
    input  logic [NEV-1:0]  ev,
    input  logic            lim_lo,
    input  logic            lim_hi,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [IW-1:0]   wr_idx,
    input  logic [31:0]     wr_data,
    input  logic [1:0]      wr_be,
    input  logic [IW-1:0]   rd_idx,
    output logic [31:0]     rd_data,
    output logic [NREG-1:0] match_lo,
    output logic [NREG-1:0] match_hi
);
    logic [NREG-1:0][31:0] value_all;
    logic [NREG-1:0]       mode_lo_all, mode_hi_all;
    wsel_e                 wsel_c;

    assign wsel_c = wsel_e'(wr_sel);

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        mcr_slot #(.NEV(NEV)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .split    (split),
            .cnt      (cnt),
            .ev       (ev),
            .lim_lo   (lim_lo),
            .lim_hi   (lim_hi),
            .sel_me   (wr_en && (wr_idx == IW'(i))),
            .wsel     (wsel_c),
            .wdata    (wr_data),
            .wbe      (wr_be),
            .value    (value_all[i]),
            .match_lo (match_lo[i]),
            .match_hi (match_hi[i]),
            .mode_lo  (mode_lo_all[i]),
            .mode_hi  (mode_hi_all[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IW'(i))
                rd_data = value_all[i];
    end
endmodule

// File: rtl/mcr_bank_chk.sv
module mcr_bank_chk
    import mcr_pkg::*;
#(
    parameter int NREG = 4,
    parameter int IW   = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  split,
    input logic                  wr_en,
    input logic [2:0]            wr_sel,
    input logic [IW-1:0]         wr_idx,
    input logic [31:0]           wr_data,
    input logic [1:0]            wr_be,
    input logic [NREG-1:0]       match_lo,
    input logic [NREG-1:0]       match_hi,
    input logic [NREG-1:0]       mode_lo_all,
    input logic [NREG-1:0]       mode_hi_all,
    input logic [NREG-1:0][31:0] value_all
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (match_lo == '0 && match_hi == '0));

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'(WS_VALUE) && wr_be == 2'b11)
            |=> value_all[$past(wr_idx)] == $past(wr_data));

    // R10
    unified_hi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !split |=> match_hi == '0);

    // R9
    capture_lo_silent_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (match_lo & $past(mode_lo_all)) == '0);

    // R9
    capture_hi_silent_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (match_hi & $past(mode_hi_all)) == '0);
endmodule

bind mcr_bank mcr_bank_chk #(.NREG(NREG), .IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .split       (split),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .wr_be       (wr_be),
    .match_lo    (match_lo),
    .match_hi    (match_hi),
    .mode_lo_all (mode_lo_all),
    .mode_hi_all (mode_hi_all),
    .value_all   (value_all)
);

// File: tb/sim_mcr_bank.sv
`timescale 1ns/1ps
module sim_mcr_bank;
    localparam int NREG = 4;
    localparam int NEV  = 8;
    localparam int IW   = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            split = 1'b0;
    logic [31:0]     cnt = 32'h1234_5678;
    logic [NEV-1:0]  ev = '0;
    logic            lim_lo = 1'b0, lim_hi = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_sel = '0;
    logic [IW-1:0]   wr_idx = '0;
    logic [31:0]     wr_data = '0;
    logic [1:0]      wr_be = '0;
    logic [IW-1:0]   rd_idx = '0;
    logic [31:0]     rd_data;
    logic [NREG-1:0] match_lo, match_hi;

    int    n_checks = 0;
    int    n_errors = 0;
    string phase_req = "R1";

    always #5 clk = ~clk;

    mcr_bank #(.NREG(NREG), .NEV(NEV)) u0 (
        .clk(clk), .rst(rst), .split(split), .cnt(cnt), .ev(ev),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be), .rd_idx(rd_idx),
        .rd_data(rd_data), .match_lo(match_lo), .match_hi(match_hi)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [31:0]     m_val [NREG];
    logic [31:0]     m_rld [NREG];
    logic            m_mdl [NREG];
    logic            m_mdh [NREG];
    logic [NEV-1:0]  m_mkl [NREG];
    logic [NEV-1:0]  m_mkh [NREG];
    logic [NREG-1:0] m_mlo, m_mhi;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                m_val[i] = '0; m_rld[i] = '0; m_mdl[i] = 0; m_mdh[i] = 0;
                m_mkl[i] = '0; m_mkh[i] = '0;
            end
            m_mlo = '0; m_mhi = '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                bit eql, eqh, cl, ch, rl, rh, me;
                logic [15:0] lo, hi;
                eql = (m_val[i][15:0] == cnt[15:0]);
                eqh = (m_val[i][31:16] == cnt[31:16]);
                m_mlo[i] = !m_mdl[i] && eql && (split || eqh);
                m_mhi[i] = split && !m_mdh[i] && eqh;
                cl = m_mdl[i] && ((ev & m_mkl[i]) != 0);
                ch = split ? (m_mdh[i] && ((ev & m_mkh[i]) != 0)) : cl;
                rl = !m_mdl[i] && lim_lo;
                rh = split ? (!m_mdh[i] && lim_hi) : rl;
                me = wr_en && (int'(wr_idx) == i);
                lo = m_val[i][15:0]; hi = m_val[i][31:16];
                if (me && wr_sel == 0 && wr_be[0]) lo = wr_data[15:0];
                else if (cl) lo = cnt[15:0];
                else if (rl) lo = m_rld[i][15:0];
                if (me && wr_sel == 0 && wr_be[1]) hi = wr_data[31:16];
                else if (ch) hi = cnt[31:16];
                else if (rh) hi = m_rld[i][31:16];
                m_val[i] = {hi, lo};
                if (me && wr_sel == 1) begin
                    if (wr_be[0]) m_rld[i][15:0]  = wr_data[15:0];
                    if (wr_be[1]) m_rld[i][31:16] = wr_data[31:16];
                end
                if (me && wr_sel == 2) begin m_mdl[i] = wr_data[0]; m_mdh[i] = wr_data[1]; end
                if (me && wr_sel == 3) m_mkl[i] = wr_data[NEV-1:0];
                if (me && wr_sel == 4) m_mkh[i] = wr_data[NEV-1:0];
            end
        end
    end

    // compare on every falling edge once the model has seen an edge
    bit model_live = 0;
    always @(posedge clk) model_live <= 1;
    always @(negedge clk) begin
        if (model_live) begin
            check(phase_req, "match_lo", 32'(match_lo), 32'(m_mlo));
            check(phase_req, "match_hi", 32'(match_hi), 32'(m_mhi));
            check(phase_req, "rd_data", rd_data, m_val[rd_idx]);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #2;
        wr_en = 0; ev = '0; lim_lo = 0; lim_hi = 0;
    endtask

    task automatic wr(input int sel, input int idx, input logic [31:0] d, input logic [1:0] be);
        wr_en = 1; wr_sel = 3'(sel); wr_idx = IW'(idx); wr_data = d; wr_be = be;
        tick();
    endtask

    task automatic rd_check(input string req, input int idx, input logic [31:0] exp);
        rd_idx = IW'(idx);
        @(negedge clk); #1;
        check(req, "rd_data directed", rd_data, exp);
    endtask

    task automatic strobe_check(input string req, input logic [3:0] elo, input logic [3:0] ehi);
        @(negedge clk); #1;
        check(req, "match_lo directed", 32'(match_lo), 32'(elo));
        check(req, "match_hi directed", 32'(match_hi), 32'(ehi));
    endtask

    initial begin
        begin : watchdog
            #(200000 * 10);
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        // R1: reset
        phase_req = "R1";
        tick(); tick(); tick();
        rst = 0;
        tick();
        strobe_check("R1", 4'b0000, 4'b0000);
        for (int i = 0; i < NREG; i++) rd_check("R1", i, 32'h0);

        // R2: writes and readback
        phase_req = "R2";
        wr(0, 1, 32'h0001_0005, 2'b11);
        wr(1, 1, 32'hAAAA_5555, 2'b11);
        wr(0, 0, 32'hFFFF_BEEF, 2'b01);
        wr(5, 0, 32'h1111_1111, 2'b11);   // code 5: no effect
        rd_check("R2", 0, 32'h0000_BEEF);
        rd_check("R2", 1, 32'h0001_0005);

        // R3: unified match
        phase_req = "R3";
        for (int k = 3; k <= 7; k++) begin cnt = 32'h0001_0000 + 32'(k); tick(); end
        cnt = 32'h0001_0005; tick();
        strobe_check("R3", 4'b0010, 4'b0000);
        cnt = 32'h0002_0005; tick();       // low half equal only
        strobe_check("R3", 4'b0000, 4'b0000);

        // R9 / R5: capture role
        phase_req = "R9";
        wr(2, 2, 32'h1, 2'b11);
        wr(3, 2, 32'h04, 2'b11);
        cnt = 32'h0; tick();
        strobe_check("R9", 4'b1000, 4'b0000);
        cnt = 32'h0BAD_F00D; ev = 8'h20; tick();
        rd_check("R9", 2, 32'h0);
        phase_req = "R5";
        ev = 8'h04; tick();
        rd_check("R5", 2, 32'h0BAD_F00D);
        phase_req = "R9";
        wr(3, 1, 32'hFF, 2'b11);
        ev = 8'hFF; tick();
        rd_check("R9", 1, 32'h0001_0005);

        // R10 / R7: unified reload
        phase_req = "R10";
        wr(4, 1, 32'hFF, 2'b11);
        lim_hi = 1; tick();
        rd_check("R10", 1, 32'h0001_0005);
        phase_req = "R7";
        lim_lo = 1; tick();
        rd_check("R7", 1, 32'hAAAA_5555);
        rd_check("R7", 0, 32'h0);

        // R4 / R6: split layout
        phase_req = "R4";
        split = 1;
        wr(0, 3, 32'h0042_0017, 2'b11);
        wr(2, 3, 32'h2, 2'b11);
        wr(4, 3, 32'h02, 2'b11);
        cnt = 32'h0042_0017; tick();
        strobe_check("R4", 4'b1000, 4'b0000);
        phase_req = "R6";
        cnt = 32'h1234_0017; ev = 8'h02; tick();
        rd_check("R6", 3, 32'h1234_0017);
        phase_req = "R4";
        cnt = 32'hAAAA_0000; tick();
        strobe_check("R4", 4'b0001, 4'b0010);

        // R7: split reload of the high half only
        phase_req = "R7";
        wr(1, 0, 32'h7777_8888, 2'b11);
        cnt = 32'h0; lim_hi = 1; tick();
        rd_check("R7", 0, 32'h7777_0000);
        rd_check("R7", 1, 32'hAAAA_5555);

        // R8: write beats capture per half
        phase_req = "R8";
        wr(2, 2, 32'h3, 2'b11);
        wr(4, 2, 32'h04, 2'b11);
        cnt = 32'h5555_6666; ev = 8'h04;
        wr(0, 2, 32'h0000_ABCD, 2'b01);
        rd_check("R8", 2, 32'h5555_ABCD);

        // mixed random traffic against the model
        phase_req = "R8";
        for (int n = 0; n < 3000; n++) begin
            if (n == 1500) split = ~split;
            cnt = {14'b0, 2'($urandom_range(0, 3)), 14'b0, 2'($urandom_range(0, 3))};
            ev = NEV'($urandom_range(0, 255)) & NEV'($urandom_range(0, 255));
            lim_lo = ($urandom_range(0, 7) == 0);
            lim_hi = ($urandom_range(0, 7) == 0);
            rd_idx = IW'($urandom_range(0, NREG - 1));
            if ($urandom_range(0, 2) == 0) begin
                wr_en = 1;
                wr_sel = 3'($urandom_range(0, 5));
                wr_idx = IW'($urandom_range(0, NREG - 1));
                wr_be = 2'($urandom_range(0, 3));
                wr_data = (wr_sel >= 3) ? 32'($urandom_range(0, 255))
                        : {14'b0, 2'($urandom_range(0, 3)), 14'b0, 2'($urandom_range(0, 3))};
            end
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule